// File: doc/BRIEF.md
# Frame Sync Confidence Counter

This block decides whether a receiver is still aligned to the incoming frame structure. Once per frame, at one designated word slot, the pattern compare logic reports whether the expected sync pattern was seen (a match) or not (a mismatch). A small saturating up/down counter turns that stream of per-frame verdicts into a confidence level. The level sits at a ceiling while alignment is healthy. Each missed pattern lowers it by one. Each seen pattern raises it again, up to the ceiling.

When the level has fallen to zero and the next evaluation slot arrives, the block declares loss of frame. It drops its sync-valid flag, freezes the level and raises a release signal. The release signal lifts the hold on an external acquisition search. That search runs on its own. When it reports lock, this block reloads the level to the ceiling, clears loss of frame and goes back to tracking.

All qualifiers are single-cycle control pulses that are sampled on the rising clock edge. No data moves through the block, so it has no valid/ready handshake and never stalls its neighbours. All outputs come from registers and change one clock after the edge that caused them, except `acq_release`, which is the plain inverse of the sync flag.

Top module: `fsc_conf_counter`

## Requirements
- R1: After reset, `sync_valid` is 0, `lof` is 0, `acq_release` is 1 and `level` equals the ceiling CEIL (5 by default).
- R2: While `sync_valid` is 1, `level` changes only on a cycle where `eval_slot` is 1. Match and mismatch pulses on other cycles have no effect.
- R3: `level` never exceeds CEIL. A match at an evaluation slot with `level` at CEIL leaves it at CEIL.
- R4: With `sync_valid` 1 and `level` between 1 and CEIL-1, a match (without mismatch) at an evaluation slot raises `level` by one on the next cycle.
- R5: With `sync_valid` 1 and `level` above 0, a mismatch at an evaluation slot lowers `level` by one on the next cycle.
- R6: When match and mismatch are both 1 at an evaluation slot, the block treats it as a mismatch.
- R7: With `sync_valid` 1, an evaluation slot that finds `level` at 0 sets `lof` to 1 and `sync_valid` to 0 on the next cycle. It does this whatever the match and mismatch inputs are, and `level` stays 0.
- R8: While `sync_valid` is 0, `eval_slot`, `match` and `mismatch` have no effect on `level`, `lof` or `sync_valid`.
- R9: `acq_release` is always the inverse of `sync_valid`.
- R10: `acq_lock` while `sync_valid` is 0 gives `sync_valid` 1, `lof` 0 and `level` = CEIL on the next cycle. `acq_lock` while `sync_valid` is 1 is ignored.
- R11: Once set, `lof` stays 1 until an `acq_lock` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| eval_slot | input | 1 | High during the designated evaluation word of each frame |
| match | input | 1 | Sync pattern seen in this frame |
| mismatch | input | 1 | Sync pattern missed in this frame |
| acq_lock | input | 1 | External acquisition reports lock |
| sync_valid | output | 1 | Frame alignment currently trusted |
| lof | output | 1 | Loss of frame latched |
| acq_release | output | 1 | Lifts the hold on external acquisition logic |
| level | output | $clog2(CEIL+1) | Current confidence level |

## Verification
The hardest case to reach is the evaluation slot that finds the level already at zero while a match is offered. The mismatch that brought the level to zero must come first, at an earlier slot. The match then has to be withheld from the decision that follows. The stimulus walks the level down one frame at a time, lets a match-only slot arrive at zero and checks that loss of frame is declared rather than a recovery. It then pulses evaluation, match and mismatch while unlocked to show that the frozen state holds until lock is reported.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  // Decision taken for the confidence level on one clock
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_UP   = 2'd1,
    ACT_DOWN = 2'd2,
    ACT_LOSE = 2'd3
  } fsc_act_e;
endpackage

// File: rtl/fsc_judge.sv
module fsc_judge
  import fsc_pkg::*;
(
  input  logic     tracking,
  input  logic     eval_slot,
  input  logic     match,
  input  logic     mismatch,
  input  logic     at_floor,
  input  logic     at_ceil,
  output fsc_act_e act
);
  always_comb begin
    act = ACT_HOLD;
    if (tracking && eval_slot) begin
      if (at_floor)                act = ACT_LOSE;
      else if (mismatch)           act = ACT_DOWN;
      else if (match && !at_ceil)  act = ACT_UP;
      else                         act = ACT_HOLD;
    end
  end
endmodule

// File: rtl/fsc_level.sv
module fsc_level
  import fsc_pkg::*;
#(
  parameter int unsigned CEIL = 5,
  parameter int unsigned LW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fsc_act_e      act,
  input  logic          reload,
  output logic [LW-1:0] level,
  output logic          at_floor,
  output logic          at_ceil
);
  localparam logic [LW-1:0] TOP = LW'(CEIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= TOP;
    end else if (reload) begin
      level <= TOP;
    end else begin
      unique case (act)
        ACT_UP:   level <= level + LW'(1);
        ACT_DOWN: level <= level - LW'(1);
        default:  level <= level;
      endcase
    end
  end

  assign at_floor = (level == '0);
  assign at_ceil  = (level >= TOP);
endmodule

// File: rtl/fsc_track.sv
module fsc_track
  import fsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  fsc_act_e act,
  input  logic     reload,
  output logic     sync_valid,
  output logic     lof
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_valid <= 1'b0;
      lof        <= 1'b0;
    end else if (reload) begin
      sync_valid <= 1'b1;
      lof        <= 1'b0;
    end else if (act == ACT_LOSE) begin
      sync_valid <= 1'b0;
      lof        <= 1'b1;
    end
  end
endmodule

// File: rtl/fsc_conf_counter.sv
module fsc_conf_counter
  import fsc_pkg::*;
#(
  parameter int unsigned CEIL = 5,
  localparam int unsigned LW = $clog2(CEIL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eval_slot,
  input  logic          match,
  input  logic          mismatch,
  input  logic          acq_lock,
  output logic          sync_valid,
  output logic          lof,
  output logic          acq_release,
  output logic [LW-1:0] level
);
  fsc_act_e act;
  logic     at_floor;
  logic     at_ceil;
  logic     reload;

  assign reload = acq_lock & ~sync_valid;

  fsc_judge u_judge (
    .tracking (sync_valid),
    .eval_slot(eval_slot),
    .match    (match),
    .mismatch (mismatch),
    .at_floor (at_floor),
    .at_ceil  (at_ceil),
    .act      (act)
  );

  fsc_level #(.CEIL(CEIL), .LW(LW)) u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .reload  (reload),
    .level   (level),
    .at_floor(at_floor),
    .at_ceil (at_ceil)
  );

  fsc_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .reload    (reload),
    .sync_valid(sync_valid),
    .lof       (lof)
  );

  assign acq_release = ~sync_valid;
endmodule

// File: rtl/fsc_conf_counter_chk.sv
module fsc_conf_counter_chk #(
  parameter int unsigned CEIL = 5,
  localparam int unsigned LW = $clog2(CEIL + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eval_slot,
  input logic          match,
  input logic          mismatch,
  input logic          acq_lock,
  input logic          sync_valid,
  input logic          lof,
  input logic          acq_release,
  input logic [LW-1:0] level
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(CEIL));

  a_r2_quiet_between_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_valid && !eval_slot) |=> $stable(level));

  a_r5_mismatch_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_valid && eval_slot && mismatch && level != '0) |=> level == $past(level) - LW'(1));

  a_r7_loss_declared: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_valid && eval_slot && level == '0) |=> (lof && !sync_valid && level == '0));

  a_r8_frozen_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_valid && !acq_lock) |=> ($stable(level) && !sync_valid && $stable(lof)));

  a_r9_release_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    acq_release == !sync_valid);

  a_r10_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_valid && acq_lock) |=> (sync_valid && !lof && level == LW'(CEIL)));

  a_r11_lof_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lof && !acq_lock) |=> lof);
endmodule

bind fsc_conf_counter fsc_conf_counter_chk #(.CEIL(CEIL)) u_chk (.*);

// File: tb/fsc_conf_counter_test.sv
module fsc_conf_counter_test;
  localparam int PERIOD = 10;
  localparam int CEIL   = 5;
  localparam int LW     = $clog2(CEIL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eval_slot = 1'b0, match = 1'b0, mismatch = 1'b0, acq_lock = 1'b0;
  logic sync_valid, lof, acq_release;
  logic [LW-1:0] level;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  // reference state
  int  m_lvl = CEIL;
  bit  m_val = 0;
  bit  m_lof = 0;
  bit  done  = 0;

  always #(PERIOD/2) clk = ~clk;

  fsc_conf_counter #(.CEIL(CEIL)) uut (
    .clk(clk), .rst_n(rst_n), .eval_slot(eval_slot), .match(match),
    .mismatch(mismatch), .acq_lock(acq_lock), .sync_valid(sync_valid),
    .lof(lof), .acq_release(acq_release), .level(level)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lvl = CEIL; m_val = 0; m_lof = 0;
    end else if (!m_val) begin
      if (acq_lock) begin m_val = 1; m_lof = 0; m_lvl = CEIL; end
    end else if (eval_slot) begin
      if (m_lvl == 0) begin m_lof = 1; m_val = 0; end
      else if (mismatch) m_lvl = m_lvl - 1;
      else if (match && m_lvl < CEIL) m_lvl = m_lvl + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase, int'(level), m_lvl, "level");
      chk(phase, int'(sync_valid), int'(m_val), "sync_valid");
      chk(phase, int'(lof), int'(m_lof), "lof");
      chk("R9", int'(acq_release), int'(!m_val), "acq_release");
    end
  end

  task automatic step(input bit e, input bit m, input bit x, input bit a);
    @(negedge clk);
    eval_slot = e; match = m; mismatch = x; acq_lock = a;
    @(negedge clk);
    eval_slot = 0; match = 0; mismatch = 0; acq_lock = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(level), CEIL, "reset level");
    chk("R1", int'(sync_valid), 0, "reset sync_valid");
    chk("R1", int'(lof), 0, "reset lof");
    chk("R1", int'(acq_release), 1, "reset release");
    rst_n = 1;

    phase = "R8";
    step(1, 0, 1, 0); step(1, 1, 0, 0); step(1, 1, 1, 0);
    chk("R8", int'(level), CEIL, "level while unlocked");

    phase = "R10";
    step(0, 0, 0, 1);
    chk("R10", int'(sync_valid), 1, "valid after lock");

    phase = "R3";
    step(1, 1, 0, 0); step(1, 1, 0, 0);
    chk("R3", int'(level), CEIL, "level at ceiling");

    phase = "R2";
    step(0, 0, 1, 0); step(0, 1, 0, 0); step(0, 1, 1, 0);
    chk("R2", int'(level), CEIL, "level off-slot");

    phase = "R5";
    step(1, 0, 1, 0); step(1, 0, 1, 0); step(1, 0, 1, 0);
    chk("R5", int'(level), CEIL - 3, "level after three misses");

    phase = "R4";
    step(1, 1, 0, 0); step(1, 1, 0, 0);
    chk("R4", int'(level), CEIL - 1, "level after two hits");

    phase = "R6";
    step(1, 1, 1, 0);
    chk("R6", int'(level), CEIL - 2, "both asserted");

    phase = "R10";
    step(0, 0, 0, 1);
    chk("R10", int'(level), CEIL - 2, "lock ignored while valid");

    phase = "R7";
    for (int i = 0; i < CEIL - 2; i++) step(1, 0, 1, 0);
    chk("R7", int'(level), 0, "level at floor");
    step(1, 1, 0, 0);
    chk("R7", int'(lof), 1, "lof after zero slot");
    chk("R7", int'(sync_valid), 0, "valid dropped");
    chk("R7", int'(level), 0, "level frozen at zero");

    phase = "R11";
    for (int i = 0; i < 6; i++) step(1, i[0], ~i[0], 0);
    chk("R11", int'(lof), 1, "lof held");
    chk("R8", int'(level), 0, "level unchanged unlocked");

    phase = "R10";
    step(0, 0, 0, 1);
    chk("R10", int'(lof), 0, "lof cleared");
    chk("R10", int'(level), CEIL, "level reloaded");

    phase = "R2";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      eval_slot = ((i % 7) == 6);
      match     = ($urandom_range(0, 2) != 0);
      mismatch  = ($urandom_range(0, 2) == 0);
      acq_lock  = ($urandom_range(0, 9) == 0);
    end
    @(negedge clk);
    eval_slot = 0; match = 0; mismatch = 0; acq_lock = 0;
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule